// File: doc/BRIEF.md
# Micro-op Dispatch Slot Controller

This block is the dispatch gate of an out-of-order core. It looks at one candidate instruction per cycle, with its micro-op count and two flags (zero latency, dependency breaking), and it collects three readiness inputs from the rest of the core: a busy mask from the register file, the number of free retire-unit entries, and an accept/refuse answer from the scheduler. It decides whether the instruction goes this cycle. If it cannot go, it names one reason.

Each cycle offers a fixed number of micro-op slots, set by the dispatch width. An instruction with more micro-ops than that width may still dispatch, but only into a cycle whose slots are all free. Its surplus micro-ops then carry into the following cycles and use up their slots first. Instructions that are both zero latency and dependency breaking dispatch without asking for destination registers. All outputs are registered, so a decision made on the inputs of cycle N shows up on the outputs in cycle N+1.

Top module: `dispatch_slot_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the carry-over and the slot count, and drives every output to zero. In the first cycle after reset no slots are free, so a valid instruction stalls with code 1. The full width is available from the cycle after that.
- R2: After each clock edge, the free slots equal the width minus the pending carry-over, with a floor of zero. The carry-over drops by the width, also with a floor of zero. This happens whether or not an instruction is offered.
- R3: An instruction whose effective count is above the width dispatches only when all width slots are free. Dispatching it sets the carry-over to the count minus the width.
- R4: An instruction whose effective count is at most the width dispatches only when that count does not exceed the free slots.
- R5: A micro-op count of zero is handled as one micro-op for slot checks, retire checks and the reserve count.
- R6: When the free retire entries are fewer than the effective count, the stall code is 2.
- R7: When the register-file busy mask is nonzero, the stall code is 3.
- R8: When the scheduler refuses the instruction, the stall code is 4 plus the scheduler's 2-bit reason, giving codes 4 to 7.
- R9: The stall code is 0 when nothing stalls. Otherwise the first failing check sets it, in this order: slots (code 1), retire (2), register file (3), scheduler (4 to 7). An instruction dispatches exactly when it is valid and the code is 0.
- R10: On dispatch, the register-allocate enable is 0 when the instruction is both zero latency and dependency breaking, and 1 in every other case.
- R11: On dispatch, the dispatch pulse and the reserve request are 1 and the reserve count equals the effective count. When nothing dispatches, all three are 0. These outputs appear one cycle after the inputs.
- R12: When the valid input is low, nothing dispatches, the stall code is 0, and the carry-over still drains as R2 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid_i | input | 1 | A candidate instruction is present |
| uop_cnt_i | input | UOP_W | Micro-op count of the candidate |
| zero_lat_i | input | 1 | Candidate has zero latency |
| dep_break_i | input | 1 | Candidate breaks dependencies |
| rf_busy_i | input | RF_W | Register-file busy mask; nonzero blocks dispatch |
| rcu_free_i | input | RCU_W | Free retire-unit entries |
| sched_ready_i | input | 1 | Scheduler accepts the candidate |
| sched_reason_i | input | 2 | Scheduler refusal reason |
| disp_o | output | 1 | Dispatch pulse (registered) |
| reg_alloc_o | output | 1 | Register allocation enable (registered) |
| rsv_req_o | output | 1 | Retire-slot reserve request (registered) |
| rsv_cnt_o | output | UOP_W | Number of retire slots to reserve (registered) |
| stall_o | output | 3 | Stall code (registered) |

## Verification
The bench uses the default build: a width of 4, a 4-bit micro-op count (up to 15), a 5-bit retire-free count and a 3-bit busy mask. A 15-micro-op instruction leaves a carry-over that needs several cycles to drain. That brings into reach the cycles with zero free slots, the partial-slot cycle, and the oversized instruction refused because one slot is still taken. The 5-bit retire count can fall below or rise above any micro-op count, and the random phase mixes all four stall sources so that every priority pairing occurs.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam logic [2:0] STALL_NONE    = 3'd0;
  localparam logic [2:0] STALL_SLOTS   = 3'd1;
  localparam logic [2:0] STALL_RETIRE  = 3'd2;
  localparam logic [2:0] STALL_REGFILE = 3'd3;
  localparam logic       STALL_SCHED_HI = 1'b1;

  typedef struct packed {
    logic       disp;
    logic       alloc;
    logic [2:0] stall;
  } dsc_decision_t;
endpackage

// File: rtl/dsc_slot_tracker.sv
module dsc_slot_tracker #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic             take_big_i,
  input  logic [UOP_W-1:0] neff_i,
  output logic [CNT_W-1:0] avail_o,
  output logic [CNT_W-1:0] carry_o
);
  localparam logic [CNT_W-1:0] WID = CNT_W'(DISP_W);

  logic [CNT_W-1:0] avail_q, carry_q;
  logic [CNT_W-1:0] carry_after, avail_nxt, carry_nxt;

  always_comb begin
    carry_after = (take_i && take_big_i) ? (CNT_W'(neff_i) - WID) : carry_q;
    avail_nxt   = (carry_after >= WID) ? '0 : (WID - carry_after);
    carry_nxt   = (carry_after > WID) ? (carry_after - WID) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= '0;
      carry_q <= '0;
    end else begin
      avail_q <= avail_nxt;
      carry_q <= carry_nxt;
    end
  end

  assign avail_o = avail_q;
  assign carry_o = carry_q;

  assert_avail_bound_R2: assert property (@(posedge clk) disable iff (rst)
    avail_q <= WID);
  assert_carry_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    (carry_q != '0) |-> (avail_q == '0));
  assert_big_leaves_no_slots_R3: assert property (@(posedge clk) disable iff (rst)
    (take_i && take_big_i) |=> (avail_q < WID));
endmodule

// File: rtl/dsc_gate.sv
module dsc_gate
  import dsc_pkg::*;
#(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int CNT_W  = 6,
  parameter int RF_W   = 3,
  parameter int RCU_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [UOP_W-1:0] uops_i,
  input  logic             zero_lat_i,
  input  logic             dep_break_i,
  input  logic [RF_W-1:0]  rf_busy_i,
  input  logic [RCU_W-1:0] rcu_free_i,
  input  logic             sched_ready_i,
  input  logic [1:0]       sched_reason_i,
  input  logic [CNT_W-1:0] avail_i,
  output logic [UOP_W-1:0] neff_o,
  output logic             big_o,
  output dsc_decision_t    dec_o
);
  logic slots_ok, rcu_ok, rf_ok;

  always_comb begin
    neff_o   = (uops_i == '0) ? UOP_W'(1) : uops_i;
    big_o    = 32'(neff_o) > DISP_W;
    slots_ok = big_o ? (32'(avail_i) == DISP_W) : (32'(neff_o) <= 32'(avail_i));
    rcu_ok   = 32'(rcu_free_i) >= 32'(neff_o);
    rf_ok    = (rf_busy_i == '0);

    dec_o.stall = STALL_NONE;
    if (valid_i) begin
      if (!slots_ok)           dec_o.stall = STALL_SLOTS;
      else if (!rcu_ok)        dec_o.stall = STALL_RETIRE;
      else if (!rf_ok)         dec_o.stall = STALL_REGFILE;
      else if (!sched_ready_i) dec_o.stall = {STALL_SCHED_HI, sched_reason_i};
    end
    dec_o.disp  = valid_i && (dec_o.stall == STALL_NONE);
    dec_o.alloc = dec_o.disp && !(zero_lat_i && dep_break_i);
  end

  assert_grant_retire_room_R6: assert property (@(posedge clk) disable iff (rst)
    dec_o.disp |-> (32'(rcu_free_i) >= 32'(neff_o)));
  assert_grant_rf_free_R7: assert property (@(posedge clk) disable iff (rst)
    dec_o.disp |-> (rf_busy_i == '0));
  assert_big_needs_full_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_o.disp && big_o) |-> (32'(avail_i) == DISP_W));
endmodule

// File: rtl/dsc_out_reg.sv
module dsc_out_reg
  import dsc_pkg::*;
#(
  parameter int UOP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  dsc_decision_t    dec_i,
  input  logic [UOP_W-1:0] neff_i,
  output logic             disp_o,
  output logic             alloc_o,
  output logic             rsv_o,
  output logic [UOP_W-1:0] rsv_cnt_o,
  output logic [2:0]       stall_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_o    <= 1'b0;
      alloc_o   <= 1'b0;
      rsv_o     <= 1'b0;
      rsv_cnt_o <= '0;
      stall_o   <= STALL_NONE;
    end else begin
      disp_o    <= dec_i.disp;
      alloc_o   <= dec_i.alloc;
      rsv_o     <= dec_i.disp;
      rsv_cnt_o <= dec_i.disp ? neff_i : '0;
      stall_o   <= dec_i.stall;
    end
  end

  assert_alloc_only_on_disp_R10: assert property (@(posedge clk) disable iff (rst)
    alloc_o |-> disp_o);
  assert_disp_no_stall_R9: assert property (@(posedge clk) disable iff (rst)
    disp_o |-> (stall_o == STALL_NONE));
  assert_rsv_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    disp_o |-> (rsv_cnt_o != '0));
endmodule

// File: rtl/dispatch_slot_ctrl.sv
module dispatch_slot_ctrl
  import dsc_pkg::*;
#(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int RF_W   = 3,
  parameter int RCU_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inst_valid_i,
  input  logic [UOP_W-1:0] uop_cnt_i,
  input  logic             zero_lat_i,
  input  logic             dep_break_i,
  input  logic [RF_W-1:0]  rf_busy_i,
  input  logic [RCU_W-1:0] rcu_free_i,
  input  logic             sched_ready_i,
  input  logic [1:0]       sched_reason_i,
  output logic             disp_o,
  output logic             reg_alloc_o,
  output logic             rsv_req_o,
  output logic [UOP_W-1:0] rsv_cnt_o,
  output logic [2:0]       stall_o
);
  localparam int WW    = $clog2(DISP_W + 1);
  localparam int CNT_W = ((UOP_W > WW) ? UOP_W : WW) + 1;

  logic [CNT_W-1:0] avail, carry;
  logic [UOP_W-1:0] neff;
  logic             big;
  dsc_decision_t    dec;

  dsc_slot_tracker #(.DISP_W(DISP_W), .UOP_W(UOP_W), .CNT_W(CNT_W)) trk_i (
    .clk(clk), .rst(rst), .take_i(dec.disp), .take_big_i(big),
    .neff_i(neff), .avail_o(avail), .carry_o(carry)
  );

  dsc_gate #(.DISP_W(DISP_W), .UOP_W(UOP_W), .CNT_W(CNT_W),
             .RF_W(RF_W), .RCU_W(RCU_W)) gate_i (
    .clk(clk), .rst(rst), .valid_i(inst_valid_i), .uops_i(uop_cnt_i),
    .zero_lat_i(zero_lat_i), .dep_break_i(dep_break_i),
    .rf_busy_i(rf_busy_i), .rcu_free_i(rcu_free_i),
    .sched_ready_i(sched_ready_i), .sched_reason_i(sched_reason_i),
    .avail_i(avail), .neff_o(neff), .big_o(big), .dec_o(dec)
  );

  dsc_out_reg #(.UOP_W(UOP_W)) oreg_i (
    .clk(clk), .rst(rst), .dec_i(dec), .neff_i(neff),
    .disp_o(disp_o), .alloc_o(reg_alloc_o), .rsv_o(rsv_req_o),
    .rsv_cnt_o(rsv_cnt_o), .stall_o(stall_o)
  );

  assert_idle_no_disp_R12: assert property (@(posedge clk) disable iff (rst)
    !inst_valid_i |=> (!disp_o && stall_o == STALL_NONE));
  assert_carry_drains_R2: assert property (@(posedge clk) disable iff (rst)
    (carry != '0 && !inst_valid_i) |=> (carry < $past(carry)));
endmodule

// File: tb/dispatch_slot_ctrl_tb.sv
module dispatch_slot_ctrl_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v = 1'b0, zl = 1'b0, db = 1'b0, sr = 1'b1;
  logic [3:0] n = '0;
  logic [2:0] rf = '0;
  logic [4:0] rcu = '0;
  logic [1:0] rsn = '0;
  logic disp, alloc, rsv;
  logic [3:0] rcnt;
  logic [2:0] stall;

  int checks = 0, errors = 0;
  int m_avail = 0, m_carry = 0;

  always #4 clk = ~clk;

  dispatch_slot_ctrl dut_i (
    .clk(clk), .rst(rst), .inst_valid_i(v), .uop_cnt_i(n),
    .zero_lat_i(zl), .dep_break_i(db), .rf_busy_i(rf), .rcu_free_i(rcu),
    .sched_ready_i(sr), .sched_reason_i(rsn), .disp_o(disp),
    .reg_alloc_o(alloc), .rsv_req_o(rsv), .rsv_cnt_o(rcnt), .stall_o(stall)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic iv, input int in, input logic izl, input logic idb,
                      input int ircu, input int irf, input logic isr, input int irsn,
                      input string tag);
    int neff, es, ca;
    logic big, sok, ed;
    v = iv; n = 4'(in); zl = izl; db = idb; rcu = 5'(ircu);
    rf = 3'(irf); sr = isr; rsn = 2'(irsn);
    neff = (in == 0) ? 1 : in;
    big = neff > W;
    sok = big ? (m_avail == W) : (neff <= m_avail);
    if (!iv) es = 0;
    else if (!sok) es = 1;
    else if (ircu < neff) es = 2;
    else if (irf != 0) es = 3;
    else if (!isr) es = 4 + irsn;
    else es = 0;
    ed = iv && (es == 0);
    ca = (ed && big) ? neff - W : m_carry;
    m_avail = (ca >= W) ? 0 : W - ca;
    m_carry = (ca > W) ? ca - W : 0;
    @(negedge clk);
    check(tag, "disp", int'(disp), int'(ed));
    check(tag, "stall", int'(stall), es);
    check(tag, "alloc", int'(alloc), int'(ed && !(izl && idb)));
    check(tag, "rsv_req", int'(rsv), int'(ed));
    check(tag, "rsv_cnt", int'(rcnt), ed ? neff : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1", "disp", int'(disp), 0);
    check("R1", "stall", int'(stall), 0);
    check("R1", "rsv_cnt", int'(rcnt), 0);
    rst = 1'b0;
    m_avail = 0; m_carry = 0;
    step(1, 1, 0, 0, 31, 0, 1, 0, "R1");   // no slots first cycle
    step(1, 3, 0, 0, 31, 0, 1, 0, "R4");
    step(1, 0, 0, 0, 31, 0, 1, 0, "R5");
    step(1, 10, 0, 0, 31, 0, 1, 0, "R3");  // carry 6
    step(1, 1, 0, 0, 31, 0, 1, 0, "R2");   // 0 slots
    step(1, 3, 0, 0, 31, 0, 1, 0, "R2");   // 2 slots
    step(1, 5, 0, 0, 31, 0, 1, 0, "R3");   // carry 1
    step(1, 5, 0, 0, 31, 0, 1, 0, "R3");   // 3 slots: refused
    step(1, 4, 0, 0, 3, 0, 1, 0, "R6");
    step(1, 2, 0, 0, 31, 2, 1, 0, "R7");
    step(1, 2, 0, 0, 31, 0, 0, 2, "R8");
    step(1, 2, 0, 0, 31, 0, 0, 3, "R8");
    step(1, 2, 0, 0, 0, 5, 0, 1, "R9");    // retire beats rf, sched
    step(1, 2, 0, 0, 31, 5, 0, 1, "R9");   // rf beats sched
    step(1, 9, 0, 0, 31, 0, 1, 0, "R3");   // carry 5
    step(1, 1, 0, 0, 0, 7, 0, 0, "R9");    // slots beat all
    step(1, 1, 1, 1, 31, 0, 1, 0, "R10");
    step(1, 1, 1, 0, 31, 0, 1, 0, "R10");
    step(1, 1, 0, 1, 31, 0, 1, 0, "R10");
    step(1, 15, 0, 0, 31, 0, 1, 0, "R3");  // carry 11
    step(0, 3, 0, 0, 31, 0, 1, 0, "R12");
    step(0, 3, 0, 0, 0, 7, 0, 0, "R12");
    step(1, 2, 0, 0, 31, 0, 1, 0, "R2");   // 1 slot
    step(1, 1, 0, 0, 31, 0, 1, 0, "R11");
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 7) != 0, $urandom_range(0, 15),
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 31), ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0,
           $urandom_range(0, 4) != 0, $urandom_range(0, 3), "R9");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule